// File: doc/BRIEF.md
# CAN Transmit Queue with Per-Slot Abort

This block is the register-mapped transmit queue that sits in front of a classic CAN bit engine. Software stages a frame by writing two payload words and a length/flags word in any order, then writes the identifier word; that last write is the commit strobe that places the frame into the next free slot. The queue presents the oldest slot to the bus engine as a request together with all frame fields. The engine answers with a one-cycle done pulse and a flag that says whether the frame went out or was given up. Each pulse pops the tail slot.

Software can also write a 16-bit abort mask with one bit per slot. Marked slots that hold pending frames are drained from the tail, one per cycle, without involving the engine. Draining halts at the first tail slot whose mark is clear. A control bit holds the queue in a quiet state in which nothing is offered to the engine, while marked slots still drain. Every pop produces a registered event that carries the slot number and an aborted flag. Head index, tail index and a sticky overflow flag are visible in a status word.

Top module: `can_txq`

## Requirements
- R1: After reset the status word reads zero (head 0, tail 0, no overflow), no request is offered to the engine and no event is signalled.
- R2: Writes to address 0 (payload low word), address 1 (payload high word) and address 2 (length word) only stage values and leave the head index unchanged. A write to address 3 (identifier word) commits the frame. The offered frame then carries identifier bits 28:0, extended flag = identifier bit 29, DLC = length bits 3:0, remote flag = length bit 4, single-shot flag = length bit 24, and payload {high word, low word}.
- R3: The status word holds the head index in bits 7:0, the tail index in bits 15:8 and the overflow flag in bit 16; every other bit reads zero.
- R4: Frames are offered in commit order, and both indices wrap to zero after slot DEPTH-1.
- R5: The queue is full when it holds DEPTH-1 frames. A commit while full changes nothing in the queue and sets the overflow flag, which stays set until reset.
- R6: A done pulse while a request is offered pops the tail slot. In the next cycle the event output is valid for one cycle with that slot number and with the aborted flag equal to the engine's flag, and the tail has advanced by one.
- R7: A done pulse while no request is offered (queue empty, quiet mode, or tail slot marked) is ignored: no event is produced and the tail does not move.
- R8: A write to address 4 marks slot i for abort when mask bit i is set and slot i currently holds a pending frame. Mask bits for slots that are not pending are discarded and do not affect frames committed later.
- R9: While the tail slot is marked, it is popped each cycle with an aborted event and no request is offered. Draining stops at the first tail slot that is not marked, which is then offered to the engine.
- R10: While control bit 0 (address 5) is set, no request is offered, but marked slots continue to drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 low payload, 1 high payload, 2 length, 3 identifier/commit, 4 abort mask, 5 control) |
| wr_data_i | input | 32 | Register write data |
| status_o | output | 32 | Head index, tail index and overflow flag |
| tx_req_o | output | 1 | Tail frame is offered to the bus engine |
| tx_id_o | output | 29 | Offered identifier |
| tx_ext_o | output | 1 | Offered extended-frame flag |
| tx_dlc_o | output | 4 | Offered data length code |
| tx_rtr_o | output | 1 | Offered remote-request flag |
| tx_single_o | output | 1 | Offered single-shot flag |
| tx_data_o | output | 64 | Offered payload, high word in bits 63:32 |
| eng_done_i | input | 1 | Engine finished with the offered frame |
| eng_aborted_i | input | 1 | Qualifies eng_done_i: frame was given up rather than sent |
| evt_valid_o | output | 1 | A slot was popped in the previous cycle |
| evt_aborted_o | output | 1 | The popped slot was aborted |
| evt_slot_o | output | 4 | Index of the popped slot |

## Verification
The hardest state to reach is a tail region in which marked and unmarked slots alternate just after the indices have wrapped. Only then does the drain stop partway, hand one frame to the engine, and resume on the next marked slot. The stimulus fills the queue across the wrap point and writes a mask with a gap after the second pending slot. It also sets a mask bit for the empty slot at the head. The bench then resolves the gap slot through the engine and watches the drain resume. Finally it reuses the slot that had the stray bit and confirms that this slot is offered rather than drained, with quiet mode switched on and off around it.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

    localparam int unsigned MASK_W = 16;

    localparam logic [2:0] ADR_LO   = 3'd0;
    localparam logic [2:0] ADR_HI   = 3'd1;
    localparam logic [2:0] ADR_LEN  = 3'd2;
    localparam logic [2:0] ADR_IDW  = 3'd3;
    localparam logic [2:0] ADR_MASK = 3'd4;
    localparam logic [2:0] ADR_CTRL = 3'd5;

    typedef struct packed {
        logic [28:0] ident;
        logic        ext;
        logic [3:0]  dlc;
        logic        rtr;
        logic        single;
        logic [63:0] payload;
    } txq_frame_t;

endpackage

// File: rtl/can_txq_store.sv
module can_txq_store
    import can_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = 3
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [PW-1:0] widx_i,
    input  txq_frame_t    wframe_i,
    input  logic [PW-1:0] ridx_i,
    output txq_frame_t    rframe_o
);

    txq_frame_t slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            slot_q[widx_i] <= wframe_i;
        end
    end

    assign rframe_o = slot_q[ridx_i];

endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl
    import can_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              quiet_i,
    input  logic              eng_done_i,
    input  logic              eng_aborted_i,
    output logic              push_o,
    output logic [PW-1:0]     head_o,
    output logic [PW-1:0]     tail_o,
    output logic              ovf_o,
    output logic              tx_req_o,
    output logic              evt_valid_o,
    output logic              evt_aborted_o,
    output logic [PW-1:0]     evt_slot_o
);

    typedef struct packed {
        logic [PW-1:0]     head;
        logic [PW-1:0]     tail;
        logic [MASK_W-1:0] mark;
        logic              ovf;
        logic              evt_valid;
        logic              evt_aborted;
        logic [PW-1:0]     evt_slot;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              empty, full, tail_marked, drain, pop;
    logic [MASK_W-1:0] pend, tail_oh;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] v);
        return (v == PW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        int hq;
        int tq;
        hq = int'(st_q.head);
        tq = int'(st_q.tail);
        for (int i = 0; i < int'(MASK_W); i++) begin
            if (i >= int'(DEPTH)) begin
                pend[i] = 1'b0;
            end else if (tq <= hq) begin
                pend[i] = (i >= tq) && (i < hq);
            end else begin
                pend[i] = (i >= tq) || (i < hq);
            end
        end
    end

    always_comb begin
        empty       = (st_q.head == st_q.tail);
        full        = (step(st_q.head) == st_q.tail);
        tail_oh     = MASK_W'(1) << st_q.tail;
        tail_marked = |(st_q.mark & tail_oh);
        drain       = !empty && tail_marked;
        tx_req_o    = !empty && !tail_marked && !quiet_i;
        pop         = drain || (tx_req_o && eng_done_i);
        push_o      = commit_i && !full;

        st_d             = st_q;
        st_d.head        = push_o ? step(st_q.head) : st_q.head;
        st_d.tail        = pop ? step(st_q.tail) : st_q.tail;
        st_d.ovf         = st_q.ovf || (commit_i && full);
        st_d.mark        = (st_q.mark | (mask_wr_i ? (mask_i & pend) : '0))
                           & ~(pop ? tail_oh : '0);
        st_d.evt_valid   = pop;
        st_d.evt_aborted = pop && (drain || eng_aborted_i);
        st_d.evt_slot    = pop ? st_q.tail : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o        = st_q.head;
    assign tail_o        = st_q.tail;
    assign ovf_o         = st_q.ovf;
    assign evt_valid_o   = st_q.evt_valid;
    assign evt_aborted_o = st_q.evt_aborted;
    assign evt_slot_o    = st_q.evt_slot;

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && full) |=> (st_q.head == $past(st_q.head)) && st_q.ovf);

    // R6
    tail_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tail != $past(st_q.tail)) |-> st_q.evt_valid);

    // R8
    mark_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mark & ~pend) == '0);

    // R9
    drain_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && tail_marked) |=> (st_q.evt_valid && st_q.evt_aborted));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_i |-> !tx_req_o);

endmodule

// File: rtl/can_txq.sv
module can_txq
    import can_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] status_o,
    output logic        tx_req_o,
    output logic [28:0] tx_id_o,
    output logic        tx_ext_o,
    output logic [3:0]  tx_dlc_o,
    output logic        tx_rtr_o,
    output logic        tx_single_o,
    output logic [63:0] tx_data_o,
    input  logic        eng_done_i,
    input  logic        eng_aborted_i,
    output logic        evt_valid_o,
    output logic        evt_aborted_o,
    output logic [3:0]  evt_slot_o
);

    localparam int unsigned PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  dlc;
        logic        rtr;
        logic        single;
        logic        quiet;
    } stage_t;

    stage_t     sg_d, sg_q;
    txq_frame_t new_frame, tail_frame;
    logic       commit, mask_wr, push, ovf;
    logic [PW-1:0] head, tail, evt_slot;

    always_comb begin
        sg_d    = sg_q;
        commit  = 1'b0;
        mask_wr = 1'b0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                ADR_LO:   sg_d.lo = wr_data_i;
                ADR_HI:   sg_d.hi = wr_data_i;
                ADR_LEN: begin
                    sg_d.dlc    = wr_data_i[3:0];
                    sg_d.rtr    = wr_data_i[4];
                    sg_d.single = wr_data_i[24];
                end
                ADR_IDW:  commit  = 1'b1;
                ADR_MASK: mask_wr = 1'b1;
                ADR_CTRL: sg_d.quiet = wr_data_i[0];
                default:  ;
            endcase
        end
        new_frame.ident   = wr_data_i[28:0];
        new_frame.ext     = wr_data_i[29];
        new_frame.dlc     = sg_q.dlc;
        new_frame.rtr     = sg_q.rtr;
        new_frame.single  = sg_q.single;
        new_frame.payload = {sg_q.hi, sg_q.lo};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    can_txq_ctrl #(.DEPTH(DEPTH), .PW(PW)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .mask_wr_i     (mask_wr),
        .mask_i        (wr_data_i[MASK_W-1:0]),
        .quiet_i       (sg_q.quiet),
        .eng_done_i    (eng_done_i),
        .eng_aborted_i (eng_aborted_i),
        .push_o        (push),
        .head_o        (head),
        .tail_o        (tail),
        .ovf_o         (ovf),
        .tx_req_o      (tx_req_o),
        .evt_valid_o   (evt_valid_o),
        .evt_aborted_o (evt_aborted_o),
        .evt_slot_o    (evt_slot)
    );

    can_txq_store #(.DEPTH(DEPTH), .PW(PW)) store_i (
        .clk      (clk),
        .we_i     (push),
        .widx_i   (head),
        .wframe_i (new_frame),
        .ridx_i   (tail),
        .rframe_o (tail_frame)
    );

    assign status_o    = {15'd0, ovf, 8'(tail), 8'(head)};
    assign tx_id_o     = tail_frame.ident;
    assign tx_ext_o    = tail_frame.ext;
    assign tx_dlc_o    = tail_frame.dlc;
    assign tx_rtr_o    = tail_frame.rtr;
    assign tx_single_o = tail_frame.single;
    assign tx_data_o   = tail_frame.payload;
    assign evt_slot_o  = 4'(evt_slot);

    // R2
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != ADR_IDW) |=> (head == $past(head)));

endmodule

// File: tb/can_txq_tb_top.sv
module can_txq_tb_top;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] status_o;
    logic        tx_req_o;
    logic [28:0] tx_id_o;
    logic        tx_ext_o;
    logic [3:0]  tx_dlc_o;
    logic        tx_rtr_o;
    logic        tx_single_o;
    logic [63:0] tx_data_o;
    logic        eng_done_i = 1'b0;
    logic        eng_aborted_i = 1'b0;
    logic        evt_valid_o;
    logic        evt_aborted_o;
    logic [3:0]  evt_slot_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    can_txq #(.DEPTH(DEPTH)) dut_i (.*);

    // {identifier word, length word, high payload, low payload}
    localparam logic [127:0] VEC [5] = '{
        {32'h0000_0123, 32'h0000_0008, 32'h1122_3344, 32'h5566_7788},
        {32'h2ABC_DEF1, 32'h0100_0013, 32'hDEAD_BEEF, 32'h0BAD_F00D},
        {32'h7FFF_FFFF, 32'hFFFF_FFE5, 32'hA5A5_5A5A, 32'hFFFF_0000},
        {32'h0000_07FF, 32'h0000_001F, 32'h0000_0001, 32'h8000_0000},
        {32'h1000_0000, 32'h0000_0000, 32'h1357_9BDF, 32'h2468_ACE0}
    };

    function automatic logic [31:0] st(input logic ov, input int tl, input int hd);
        return {15'd0, ov, 8'(tl), 8'(hd)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic eng(input logic ab);
        @(negedge clk);
        eng_done_i = 1'b1; eng_aborted_i = ab;
        @(negedge clk);
        eng_done_i = 1'b0; eng_aborted_i = 1'b0;
    endtask

    task automatic chk_evt(input string tag, input logic ab, input int slot);
        chk({tag, " event valid"}, 64'(evt_valid_o), 64'd1);
        chk({tag, " event aborted"}, 64'(evt_aborted_o), 64'(ab));
        chk({tag, " event slot"}, 64'(evt_slot_o), 64'(slot));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R3
        chk("R1 status", 64'(status_o), 64'(st(0, 0, 0)));
        chk("R1 request", 64'(tx_req_o), 64'd0);
        chk("R1 event", 64'(evt_valid_o), 64'd0);

        // R2 staging writes alone do not enqueue
        wr(3'd1, 32'hCAFE_0001);
        wr(3'd0, 32'hCAFE_0000);
        wr(3'd2, 32'h0000_0004);
        chk("R2 staging head", 64'(status_o), 64'(st(0, 0, 0)));
        chk("R2 staging request", 64'(tx_req_o), 64'd0);

        // table walk: commit all, then pop in order (R2, R4, R6)
        for (int i = 0; i < 5; i++) begin
            wr(3'd1, VEC[i][63:32]);
            wr(3'd0, VEC[i][31:0]);
            wr(3'd2, VEC[i][95:64]);
            wr(3'd3, VEC[i][127:96]);
            chk("R3 head after commit", 64'(status_o), 64'(st(0, 0, i + 1)));
        end
        for (int i = 0; i < 5; i++) begin
            logic [31:0] iw, lw;
            iw = VEC[i][127:96];
            lw = VEC[i][95:64];
            chk("R4 request", 64'(tx_req_o), 64'd1);
            chk("R2 ident", 64'(tx_id_o), 64'(iw[28:0]));
            chk("R2 ext", 64'(tx_ext_o), 64'(iw[29]));
            chk("R2 dlc", 64'(tx_dlc_o), 64'(lw[3:0]));
            chk("R2 rtr", 64'(tx_rtr_o), 64'(lw[4]));
            chk("R2 single", 64'(tx_single_o), 64'(lw[24]));
            chk("R4 payload order", tx_data_o, {VEC[i][63:32], VEC[i][31:0]});
            eng(1'(i % 2));
            chk_evt("R6", 1'(i % 2), i);
            chk("R6 tail advance", 64'(status_o), 64'(st(0, i + 1, 5)));
        end
        @(negedge clk);
        chk("R6 event one cycle", 64'(evt_valid_o), 64'd0);

        // R7 done while empty is ignored
        eng(1'b0);
        chk("R7 empty done", 64'(evt_valid_o), 64'd0);
        chk("R7 empty tail", 64'(status_o), 64'(st(0, 5, 5)));

        // fill across the wrap to full (R4, R5)
        for (int i = 0; i < DEPTH - 1; i++) wr(3'd3, 32'(100 + i));
        chk("R4 wrap head", 64'(status_o), 64'(st(0, 5, 4)));
        wr(3'd3, 32'h0000_0777);
        chk("R5 full commit ignored", 64'(status_o), 64'(st(1, 5, 4)));
        chk("R5 tail frame intact", 64'(tx_id_o), 64'd100);

        // R8, R9 drain with a gap; bit 4 names the free head slot
        wr(3'd4, 32'h0000_0071);
        chk("R9 no event at mask write", 64'(evt_valid_o), 64'd0);
        @(negedge clk);
        chk_evt("R9 drain 5", 1'b1, 5);
        @(negedge clk);
        chk_evt("R9 drain 6", 1'b1, 6);
        @(negedge clk);
        chk("R9 drain stops", 64'(evt_valid_o), 64'd0);
        chk("R9 stop tail", 64'(status_o), 64'(st(1, 7, 4)));
        chk("R9 gap offered", 64'(tx_req_o), 64'd1);
        chk("R9 gap frame", 64'(tx_id_o), 64'd102);
        eng(1'b0);
        chk_evt("R6 gap sent", 1'b0, 7);
        @(negedge clk);
        chk_evt("R9 drain resumes 0", 1'b1, 0);
        @(negedge clk);
        chk("R9 second stop", 64'(evt_valid_o), 64'd0);
        chk("R5 overflow sticky", 64'(status_o), 64'(st(1, 1, 4)));

        // R10 quiet mode
        wr(3'd5, 32'h0000_0001);
        chk("R10 no request", 64'(tx_req_o), 64'd0);
        eng(1'b0);
        chk("R7 quiet done ignored", 64'(evt_valid_o), 64'd0);
        chk("R7 quiet tail", 64'(status_o), 64'(st(1, 1, 4)));
        wr(3'd4, 32'h0000_FFFF);
        @(negedge clk);
        chk_evt("R10 quiet drain 1", 1'b1, 1);
        @(negedge clk);
        chk_evt("R10 quiet drain 2", 1'b1, 2);
        @(negedge clk);
        chk_evt("R10 quiet drain 3", 1'b1, 3);
        @(negedge clk);
        chk("R10 drained empty", 64'(status_o), 64'(st(1, 4, 4)));

        // R8 stray mask bits do not hit a later commit
        wr(3'd3, 32'h0000_0555);
        chk("R10 quiet holds request", 64'(tx_req_o), 64'd0);
        wr(3'd5, 32'h0000_0000);
        chk("R8 new slot offered", 64'(tx_req_o), 64'd1);
        chk("R8 new slot not drained", 64'(evt_valid_o), 64'd0);
        @(negedge clk);
        chk("R8 tail held", 64'(status_o), 64'(st(1, 4, 5)));
        eng(1'b1);
        chk_evt("R6 engine abort", 1'b1, 4);
        chk("R6 final status", 64'(status_o), 64'(st(1, 5, 5)));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule